// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This block compares two IEEE-754 binary64 operands and returns a one-hot condition code naming the relation between them: less, greater, equal or unordered. It also returns two invalid-operation flags. One flag marks a signalling NaN among the inputs. The other marks an invalid compare, and it can only be raised by the ordered compare variant. Narrower formats are expected to be widened to double before they reach the unit. The unit writes no status register and raises no trap; the surrounding pipeline decides what to do with the flags.

A mode input picks the unordered or the ordered compare. A second input carries the state of the invalid-operation exception enable, which the ordered variant consults. The result is settled in a fixed order. NaNs are tested first. A pair of zeros is tested next, regardless of sign. Then the signs are compared, then the operand classes (zero, finite nonzero, infinity), and only then the magnitudes. The decision logic is combinational and is followed by a single output register stage with a valid bit. The exponent and fraction widths are parameters, so a reduced format can be used for exhaustive checking.

Top module: `fpcmp_unit`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `out_valid` is high and `cc` is exactly one-hot. The bit positions are: bit 3 less, bit 2 greater, bit 1 equal, bit 0 unordered. When `in_valid` is low, `out_valid` drops in the next cycle and `cc` and both flags hold their previous values.
- R2: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If the fraction MSB is set the NaN is quiet; if it is clear the NaN is signalling. If either operand is a NaN, `cc` is 4'b0001 (unordered only).
- R3: If either operand is a signalling NaN, `flag_snan` is 1 in both compare modes.
- R4: With `ordered_mode` = 1 and at least one NaN operand, `flag_vxc` is 1 exactly when `inv_enable` is 1 or either operand is a quiet NaN.
- R5: With `ordered_mode` = 0, `flag_vxc` is always 0.
- R6: For any pair with no NaN operand, both `flag_snan` and `flag_vxc` are 0.
- R7: Two zeros compare equal whatever their signs.
- R8: When the signs differ and the operands are not both zero, the negative operand is less.
- R9: For operands of the same sign, the class alone decides when the classes differ: infinity has a larger magnitude than any finite nonzero value, and a finite nonzero value has a larger magnitude than zero. Subnormals count as finite nonzero.
- R10: When both operands are negative, the magnitude relation is inverted: the larger magnitude is less.
- R11: Two infinities of the same sign compare equal.
- R12: Two finite nonzero operands of the same sign compare by exact value. They are equal only when they are bitwise identical.
- R13: During and right after a synchronous active-low reset, `out_valid`, `cc`, `flag_snan` and `flag_vxc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| ordered_mode | input | 1 | 1 selects the ordered compare, 0 the unordered compare |
| inv_enable | input | 1 | State of the invalid-operation exception enable |
| out_valid | output | 1 | Registered result is valid |
| cc | output | 4 | One-hot condition code {less, greater, equal, unordered} |
| flag_snan | output | 1 | A signalling NaN was an operand |
| flag_vxc | output | 1 | Invalid compare in ordered mode |

## Verification
The assertions check on every cycle the properties that follow from input fields alone. These are: a one-hot code, unordered for any NaN, the signalling-NaN flag, the ordered-mode quiet-NaN flag, a quiet `flag_vxc` in unordered mode, clear flags on ordered results, and signed zeros comparing equal. The actual ordering among numbers, meaning sign inversion for negatives, class precedence, subnormal handling and exact value comparison, is shown only by the bench. The bench sweeps every operand pair of a 7-bit reduced format under all four control combinations and checks each result against the real value it computes for each encoding.

// File: rtl/fpcmp_pkg.sv
// Package: shared class encoding and condition-code bit positions for the
// floating-point compare unit. The class values of ZERO, FIN and INF are
// ordered by magnitude, so an unsigned compare of two classes ranks them.
package fpcmp_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_FIN  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fp_cls_e;

    localparam int CC_LT = 3;
    localparam int CC_GT = 2;
    localparam int CC_EQ = 1;
    localparam int CC_UN = 0;
    localparam int CC_W  = 4;

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Splits one operand into its sign, its class and its unsigned magnitude
// field {exponent, fraction}. Assumes the IEEE-754 layout sign|exp|frac.
// Subnormals are reported as finite nonzero values.
module fpcmp_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic                 [W-1:0] op,
    output logic                         sign,
    output fpcmp_pkg::fp_cls_e           cls,
    output logic                 [W-2:0] mag
);
    import fpcmp_pkg::*;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign sign   = op[W-1];
    assign exp_f  = op[W-2 -: EXP_W];
    assign frac_f = op[FRAC_W-1:0];
    assign mag    = op[W-2:0];

    // Assign the class from the exponent and fraction fields.
    always_comb begin
        if (&exp_f) begin
            if (frac_f == '0)
                cls = CLS_INF;
            else if (frac_f[FRAC_W-1])
                cls = CLS_QNAN;
            else
                cls = CLS_SNAN;
        end else if (exp_f == '0 && frac_f == '0) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_FIN;
        end
    end

endmodule

// File: rtl/fpcmp_decide.sv
// Module: fpcmp_decide
// Combinational compare decision. It works from the classified operands in a
// fixed order: NaN, both zero, sign, class, then magnitude. Assumes the inputs
// come from fpcmp_classify.
module fpcmp_decide #(
    parameter int MAG_W = 63
) (
    input  logic                          sign_a,
    input  fpcmp_pkg::fp_cls_e            cls_a,
    input  logic              [MAG_W-1:0] mag_a,
    input  logic                          sign_b,
    input  fpcmp_pkg::fp_cls_e            cls_b,
    input  logic              [MAG_W-1:0] mag_b,
    input  logic                          ordered_mode,
    input  logic                          inv_enable,
    output logic     [fpcmp_pkg::CC_W-1:0] cc,
    output logic                          snan,
    output logic                          vxc
);
    import fpcmp_pkg::*;

    logic qnan_any, snan_any, nan_any;
    logic mag_lt, mag_gt;

    assign qnan_any = (cls_a == CLS_QNAN) || (cls_b == CLS_QNAN);
    assign snan_any = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
    assign nan_any  = qnan_any || snan_any;

    // Rank the magnitudes: the class decides first, the bit field next.
    always_comb begin
        mag_lt = 1'b0;
        mag_gt = 1'b0;
        if (cls_a < cls_b)
            mag_lt = 1'b1;
        else if (cls_a > cls_b)
            mag_gt = 1'b1;
        else if (cls_a == CLS_FIN) begin
            mag_lt = mag_a < mag_b;
            mag_gt = mag_a > mag_b;
        end
    end

    // Produce the condition code and the two invalid flags.
    always_comb begin
        cc   = '0;
        snan = 1'b0;
        vxc  = 1'b0;
        if (nan_any) begin
            cc[CC_UN] = 1'b1;
            snan      = snan_any;
            vxc       = ordered_mode && (inv_enable || qnan_any);
        end else if (cls_a == CLS_ZERO && cls_b == CLS_ZERO) begin
            cc[CC_EQ] = 1'b1;
        end else if (sign_a != sign_b) begin
            if (sign_a) cc[CC_LT] = 1'b1;
            else        cc[CC_GT] = 1'b1;
        end else if (mag_lt) begin
            if (sign_a) cc[CC_GT] = 1'b1;
            else        cc[CC_LT] = 1'b1;
        end else if (mag_gt) begin
            if (sign_a) cc[CC_LT] = 1'b1;
            else        cc[CC_GT] = 1'b1;
        end else begin
            cc[CC_EQ] = 1'b1;
        end
    end

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Floating-point compare with a one-hot condition code and invalid flags.
// Both operands are classified, a combinational decision is made, and one
// register stage follows. Assumes the inputs are already widened to the
// configured format. Outputs update only on cycles with in_valid high.
module fpcmp_unit #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         ordered_mode,
    input  logic         inv_enable,
    output logic         out_valid,
    output logic [3:0]   cc,
    output logic         flag_snan,
    output logic         flag_vxc
);
    import fpcmp_pkg::*;

    localparam int MAG_W = W - 1;

    logic             sign_a, sign_b;
    fp_cls_e          cls_a, cls_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic [CC_W-1:0]  cc_d;
    logic             snan_d, vxc_d;

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .op(op_a), .sign(sign_a), .cls(cls_a), .mag(mag_a)
    );

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .op(op_b), .sign(sign_b), .cls(cls_b), .mag(mag_b)
    );

    fpcmp_decide #(.MAG_W(MAG_W)) u_decide (
        .sign_a(sign_a), .cls_a(cls_a), .mag_a(mag_a),
        .sign_b(sign_b), .cls_b(cls_b), .mag_b(mag_b),
        .ordered_mode(ordered_mode), .inv_enable(inv_enable),
        .cc(cc_d), .snan(snan_d), .vxc(vxc_d)
    );

    // Register the result on valid input cycles and track the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cc        <= '0;
            flag_snan <= 1'b0;
            flag_vxc  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cc        <= cc_d;
                flag_snan <= snan_d;
                flag_vxc  <= vxc_d;
            end
        end
    end

endmodule

// File: rtl/fpcmp_chk.sv
// Module: fpcmp_chk
// Assertion checker bound to fpcmp_unit. It decodes NaN and zero directly
// from the operand ports and checks the registered outputs one cycle later.
module fpcmp_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         ordered_mode,
    input logic         inv_enable,
    input logic         out_valid,
    input logic [3:0]   cc,
    input logic         flag_snan,
    input logic         flag_vxc
);
    logic nan_a, nan_b, qn_a, qn_b, sn_a, sn_b, zero_both;

    assign nan_a     = (&op_a[W-2 -: EXP_W]) && (op_a[FRAC_W-1:0] != '0);
    assign nan_b     = (&op_b[W-2 -: EXP_W]) && (op_b[FRAC_W-1:0] != '0);
    assign qn_a      = nan_a && op_a[FRAC_W-1];
    assign qn_b      = nan_b && op_b[FRAC_W-1];
    assign sn_a      = nan_a && !op_a[FRAC_W-1];
    assign sn_b      = nan_b && !op_b[FRAC_W-1];
    assign zero_both = (op_a[W-2:0] == '0) && (op_b[W-2:0] == '0);

    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(cc) == 1)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (nan_a || nan_b)) |=> (cc == 4'b0001)); // R2
    AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sn_a || sn_b)) |=> flag_snan); // R3
    AST_ORDERED_QNAN_VXC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ordered_mode && (qn_a || qn_b)) |=> flag_vxc); // R4
    AST_UNORDERED_NO_VXC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ordered_mode) |=> !flag_vxc); // R5
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cc[0]) |-> (!flag_snan && !flag_vxc)); // R6
    AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_both) |=> (cc == 4'b0010)); // R7

endmodule

bind fpcmp_unit fpcmp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .ordered_mode(ordered_mode), .inv_enable(inv_enable),
    .out_valid(out_valid), .cc(cc), .flag_snan(flag_snan), .flag_vxc(flag_vxc)
);

// File: tb/tb_fpcmp_unit.sv
`timescale 1ns/1ps
module tb_fpcmp_unit;
    localparam int EW = 3;
    localparam int FW = 3;
    localparam int W  = 1 + EW + FW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         ordered_mode = 1'b0;
    logic         inv_enable = 1'b0;
    logic         out_valid;
    logic [3:0]   cc;
    logic         flag_snan;
    logic         flag_vxc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fpcmp_unit #(.EXP_W(EW), .FRAC_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .ordered_mode(ordered_mode), .inv_enable(inv_enable),
        .out_valid(out_valid), .cc(cc), .flag_snan(flag_snan), .flag_vxc(flag_vxc)
    );

    function automatic bit is_nan(input logic [W-1:0] x);
        return (x[5:3] == 3'd7) && (x[2:0] != 3'd0);
    endfunction

    // Signed value scaled to an integer; infinity maps past every finite value.
    function automatic int value_of(input logic [W-1:0] x);
        int e = int'(x[5:3]);
        int f = int'(x[2:0]);
        int m;
        if (e == 7)      m = 4096;
        else if (e == 0) m = f;
        else             m = (8 + f) << (e - 1);
        return x[6] ? -m : m;
    endfunction

    // Pick the requirement a vector exercises, for the failure message.
    function automatic string tag_of(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input bit ordm);
        if (is_nan(a) || is_nan(b)) return ordm ? "R2/R3/R4" : "R2/R3/R5";
        if (a[5:0] == 0 && b[5:0] == 0) return "R7";
        if (a[6] != b[6]) return "R8";
        if (a[5:3] == 3'd7 && b[5:3] == 3'd7) return "R11";
        if (a[6]) return "R10";
        if ((a[5:3] == 7) != (b[5:3] == 7) || (a[5:0] == 0) != (b[5:0] == 0))
            return "R9";
        return "R12";
    endfunction

    task automatic check_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                             input bit ordm, input bit en);
        logic [3:0] exp_cc;
        logic       exp_sn, exp_vx;
        bit         na = is_nan(a);
        bit         nb = is_nan(b);
        bit         qa = na && a[2];
        bit         qb = nb && b[2];
        int         va, vb;
        if (na || nb) begin
            exp_cc = 4'b0001;
            exp_sn = (na && !a[2]) || (nb && !b[2]);
            exp_vx = ordm && (en || qa || qb);
        end else begin
            va = value_of(a);
            vb = value_of(b);
            exp_cc = (va < vb) ? 4'b1000 : (va > vb) ? 4'b0100 : 4'b0010;
            exp_sn = 1'b0;  // R6
            exp_vx = 1'b0;  // R6
        end
        checks++;
        if (!out_valid || cc != exp_cc || flag_snan != exp_sn || flag_vxc != exp_vx) begin
            errors++;
            $display("FAIL %s a=%02h b=%02h ord=%0d en=%0d actual v=%0d cc=%b sn=%0d vx=%0d expected v=1 cc=%b sn=%0d vx=%0d",
                     tag_of(a, b, ordm), a, b, ordm, en, out_valid, cc, flag_snan,
                     flag_vxc, exp_cc, exp_sn, exp_vx);
        end
        checks++;
        if ($countones(cc) != 1) begin  // R1
            errors++;
            $display("FAIL R1 one-hot actual cc=%b expected one bit set", cc);
        end
    endtask

    initial begin
        logic [3:0] last_cc;
        logic       last_sn, last_vx;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid || cc != 4'b0 || flag_snan || flag_vxc) begin  // R13
            errors++;
            $display("FAIL R13 reset actual v=%0d cc=%b sn=%0d vx=%0d expected all zero",
                     out_valid, cc, flag_snan, flag_vxc);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int mode = 0; mode < 4; mode++) begin
            for (int ia = 0; ia < 128; ia++) begin
                for (int ib = 0; ib < 128; ib++) begin
                    @(negedge clk);
                    in_valid     = 1'b1;
                    op_a         = W'(ia);
                    op_b         = W'(ib);
                    ordered_mode = mode[1];
                    inv_enable   = mode[0];
                    @(posedge clk);
                    #1;
                    check_vec(W'(ia), W'(ib), mode[1], mode[0]);
                end
            end
        end
        // R1: with in_valid low the valid bit drops and the result holds.
        last_cc = cc;
        last_sn = flag_snan;
        last_vx = flag_vxc;
        @(negedge clk);
        in_valid = 1'b0;
        op_a     = 7'h00;
        op_b     = 7'h40;
        @(posedge clk);
        #1;
        checks++;
        if (out_valid || cc != last_cc || flag_snan != last_sn || flag_vxc != last_vx) begin
            errors++;
            $display("FAIL R1 hold actual v=%0d cc=%b expected v=0 cc=%b", out_valid, cc, last_cc);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule